// File: doc/BRIEF.md
# Bidirectional Systolic Edit-Distance Array

This block scores how far apart two nucleotide strings are. It uses a linear chain of identical elements. The source string enters the chain from the left end and the target string enters from the right end, so the two streams cross. Each element keeps one running distance. Whenever a source character and a target character reach the same element in the same cycle, that element fills one cell of the dynamic-programming table. It uses the distance it already holds and the distances carried in by the two streams. A character that passes an element with nothing coming the other way simply lays its carried distance into that element.

A comparison is started by feeding both strings on the same cycle, one character every second cycle, with empty slots between characters. The block supplies the table's edge values itself: the i-th source character carries i times the deletion cost, and the j-th target character carries j times the insertion cost. Once both inputs have stayed empty long enough for the chain to drain, the block does three things: it reads the distance from the element where the last pair of characters met, it presents that distance with a one-cycle done pulse, and it clears the chain for the next comparison.

Top module: `edit_dist_array`

## Requirements
- R1: Characters use a 3-bit code: 0 is an empty slot and 1, 2, 3, 4 stand for A, C, G, T. A comparison feeds both strings starting on the same cycle, one character every other cycle with an empty slot between characters. Each string is at most MAX_LEN characters long.
- R2: For two non-empty strings of equal length, `dist_o` at the done pulse is the minimum edit cost, with insertion 1, deletion 1, substitution of a different letter 2 and a matching letter 0.
- R3: The same result holds when the two strings differ in length, including the case of one character against MAX_LEN characters.
- R4: When exactly one string is empty, the result is the other string's length times its per-character cost (deletion for source characters, insertion for target characters).
- R5: Two identical strings give a result of 0.
- R6: Distances saturate at 2^DIST_W-1 and never wrap. A comparison whose true cost exceeds that limit reports the limit.
- R7: Each comparison produces exactly one `done_o` pulse, one cycle wide, no later than 3*(2*MAX_LEN-1) cycles after its last character.
- R8: While both inputs carry only empty slots and no comparison is in progress, `done_o` stays low.
- R9: A comparison started right after the previous done pulse gives the same result as it would from reset.
- R10: After reset `dist_o` is 0 and `done_o` is low. `dist_o` changes only together with a done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_char_i | input | 3 | Source character entering the left end (0 = empty) |
| tgt_char_i | input | 3 | Target character entering the right end (0 = empty) |
| dist_o | output | DIST_W | Distance of the latest finished comparison |
| done_o | output | 1 | One-cycle pulse when `dist_o` takes a new result |

## Verification
The string pairs are chosen to move the meeting element of the last character pair across the whole chain. They include equal lengths, short against long in both directions, and one string empty on either side. This separates errors in the result multiplexer from errors in the element update rule. Identical, fully different and reversed strings test the match, substitution and insert/delete branches of the minimum one at a time. Every pair is also run through a second copy with 4-bit distances, which exposes any wrap where saturation is required. Back-to-back comparisons show whether state left over from the previous comparison leaks into the next one.

// File: rtl/edist_pkg.sv
package edist_pkg;

   localparam int CHAR_W = 3;

   typedef enum logic [CHAR_W-1:0] {
      NUC_NONE = 3'd0,
      NUC_A    = 3'd1,
      NUC_C    = 3'd2,
      NUC_G    = 3'd3,
      NUC_T    = 3'd4
   } nuc_e;

   // addition clamped at a limit, used for all distance arithmetic
   function automatic int unsigned sat_add(int unsigned a, int unsigned b, int unsigned lim);
      int unsigned s;
      s = a + b;
      return (s > lim) ? lim : s;
   endfunction

   function automatic int unsigned min3(int unsigned a, int unsigned b, int unsigned c);
      int unsigned m;
      m = (a < b) ? a : b;
      return (c < m) ? c : m;
   endfunction

endpackage

// File: rtl/edist_pe.sv
module edist_pe #(
   parameter int DIST_W   = 8,
   parameter int INS_COST = 1,
   parameter int DEL_COST = 1,
   parameter int SUB_COST = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr_i,
   input  logic [edist_pkg::CHAR_W-1:0] s_chr_i,
   input  logic [DIST_W-1:0]            s_dst_i,
   input  logic [edist_pkg::CHAR_W-1:0] t_chr_i,
   input  logic [DIST_W-1:0]            t_dst_i,
   output logic [edist_pkg::CHAR_W-1:0] s_chr_o,
   output logic [edist_pkg::CHAR_W-1:0] t_chr_o,
   output logic [DIST_W-1:0]            dst_o
);
   import edist_pkg::*;

   localparam int unsigned DMAX = (32'd1 << DIST_W) - 1;

   logic                s_on, t_on;
   logic [DIST_W-1:0]   dist_q, dist_d;
   int unsigned         via_sub, via_del, via_ins, best, floor_v;

   assign s_on = (s_chr_i != '0);
   assign t_on = (t_chr_i != '0);

   always_comb begin
      via_sub = sat_add(32'(dist_q), (s_chr_i == t_chr_i) ? 32'd0 : 32'(SUB_COST), DMAX);
      via_del = sat_add(32'(t_dst_i), 32'(DEL_COST), DMAX);
      via_ins = sat_add(32'(s_dst_i), 32'(INS_COST), DMAX);
      best    = min3(via_sub, via_del, via_ins);
      floor_v = min3(32'(dist_q), 32'(t_dst_i), 32'(s_dst_i));
   end

   always_comb begin
      unique case ({s_on, t_on})
         2'b11:   dist_d = DIST_W'(best);
         2'b10:   dist_d = s_dst_i;
         2'b01:   dist_d = t_dst_i;
         default: dist_d = dist_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_chr_o <= '0;
         t_chr_o <= '0;
         dist_q  <= '0;
      end else begin
         s_chr_o <= s_chr_i;
         t_chr_o <= t_chr_i;
         dist_q  <= clr_i ? '0 : dist_d;
      end
   end

   assign dst_o = dist_q;

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!s_on && !t_on && !clr_i) |=> $stable(dst_o));                       // R2

   AST_SUB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (s_on && t_on && !clr_i) |=> (32'(dst_o) <= $past(via_sub)));          // R2

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (s_on && t_on && !clr_i) |=> (32'(dst_o) >= $past(floor_v)));          // R6

endmodule

// File: rtl/edist_ctrl.sv
module edist_ctrl #(
   parameter int MAX_LEN  = 8,
   parameter int DIST_W   = 8,
   parameter int INS_COST = 1,
   parameter int DEL_COST = 1,
   parameter int N_PE     = 15
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [edist_pkg::CHAR_W-1:0] src_char_i,
   input  logic [edist_pkg::CHAR_W-1:0] tgt_char_i,
   output logic [DIST_W-1:0]            src_bnd_o,
   output logic [DIST_W-1:0]            tgt_bnd_o,
   output logic [DIST_W-1:0]            src_acc_o,
   output logic [DIST_W-1:0]            tgt_acc_o,
   output logic [$clog2(MAX_LEN+1)-1:0] src_len_o,
   output logic [$clog2(MAX_LEN+1)-1:0] tgt_len_o,
   output logic                         fire_o
);
   import edist_pkg::*;

   localparam int unsigned DMAX     = (32'd1 << DIST_W) - 1;
   localparam int          IDLE_LIM = N_PE + 2;
   localparam int          CNT_W    = $clog2(IDLE_LIM + 1);

   logic             active_q;
   logic [CNT_W-1:0] idle_q;
   logic             s_in, t_in;

   assign s_in = (src_char_i != '0);
   assign t_in = (tgt_char_i != '0);

   assign src_bnd_o = DIST_W'(sat_add(32'(src_acc_o), 32'(DEL_COST), DMAX));
   assign tgt_bnd_o = DIST_W'(sat_add(32'(tgt_acc_o), 32'(INS_COST), DMAX));
   assign fire_o    = active_q && (32'(idle_q) == IDLE_LIM) && !s_in && !t_in;

   always_ff @(posedge clk) begin
      if (!rst_n || fire_o) begin
         active_q  <= 1'b0;
         idle_q    <= '0;
         src_len_o <= '0;
         tgt_len_o <= '0;
         src_acc_o <= '0;
         tgt_acc_o <= '0;
      end else begin
         if (s_in) begin
            src_len_o <= src_len_o + 1'b1;
            src_acc_o <= src_bnd_o;
         end
         if (t_in) begin
            tgt_len_o <= tgt_len_o + 1'b1;
            tgt_acc_o <= tgt_bnd_o;
         end
         if (s_in || t_in) begin
            active_q <= 1'b1;
            idle_q   <= '0;
         end else if (active_q && (32'(idle_q) < IDLE_LIM)) begin
            idle_q <= idle_q + 1'b1;
         end
      end
   end

   AST_SRC_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      s_in |-> (32'(src_len_o) < MAX_LEN));                                  // R1

   AST_TGT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      t_in |-> (32'(tgt_len_o) < MAX_LEN));                                  // R1

   AST_NO_IDLE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |-> (src_len_o != '0 || tgt_len_o != '0));                      // R8

endmodule

// File: rtl/edit_dist_array.sv
module edit_dist_array #(
   parameter int MAX_LEN  = 8,
   parameter int DIST_W   = 8,
   parameter int INS_COST = 1,
   parameter int DEL_COST = 1,
   parameter int SUB_COST = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        src_char_i,
   input  logic [2:0]        tgt_char_i,
   output logic [DIST_W-1:0] dist_o,
   output logic              done_o
);
   import edist_pkg::*;

   localparam int N_PE  = 2 * MAX_LEN - 1;
   localparam int MID   = MAX_LEN - 1;
   localparam int LEN_W = $clog2(MAX_LEN + 1);

   if (MAX_LEN < 1) begin : g_bad_len
      $error("MAX_LEN must be at least 1");
   end
   if (DIST_W < 2 || DIST_W > 16) begin : g_bad_width
      $error("DIST_W must lie in 2..16");
   end
   if (INS_COST >= (1 << DIST_W) || DEL_COST >= (1 << DIST_W) || SUB_COST >= (1 << DIST_W))
   begin : g_bad_cost
      $error("costs must fit in DIST_W bits");
   end

   logic [CHAR_W-1:0] sc_bus  [N_PE];
   logic [CHAR_W-1:0] tc_bus  [N_PE];
   logic [DIST_W-1:0] pe_dist [N_PE];

   logic [DIST_W-1:0] src_bnd, tgt_bnd, src_acc, tgt_acc;
   logic [LEN_W-1:0]  src_len, tgt_len;
   logic              fire;

   edist_ctrl #(
      .MAX_LEN (MAX_LEN),
      .DIST_W  (DIST_W),
      .INS_COST(INS_COST),
      .DEL_COST(DEL_COST),
      .N_PE    (N_PE)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_char_i(src_char_i),
      .tgt_char_i(tgt_char_i),
      .src_bnd_o (src_bnd),
      .tgt_bnd_o (tgt_bnd),
      .src_acc_o (src_acc),
      .tgt_acc_o (tgt_acc),
      .src_len_o (src_len),
      .tgt_len_o (tgt_len),
      .fire_o    (fire)
   );

   for (genvar k = 0; k < N_PE; k++) begin : g_pe
      logic [CHAR_W-1:0] s_chr, t_chr;
      logic [DIST_W-1:0] s_dst, t_dst;

      if (k == 0) begin : g_left_edge
         assign s_chr = src_char_i;
         assign s_dst = src_bnd;
      end else begin : g_left_link
         assign s_chr = sc_bus[k-1];
         assign s_dst = pe_dist[k-1];
      end

      if (k == N_PE - 1) begin : g_right_edge
         assign t_chr = tgt_char_i;
         assign t_dst = tgt_bnd;
      end else begin : g_right_link
         assign t_chr = tc_bus[k+1];
         assign t_dst = pe_dist[k+1];
      end

      edist_pe #(
         .DIST_W  (DIST_W),
         .INS_COST(INS_COST),
         .DEL_COST(DEL_COST),
         .SUB_COST(SUB_COST)
      ) u_pe (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr_i  (fire),
         .s_chr_i(s_chr),
         .s_dst_i(s_dst),
         .t_chr_i(t_chr),
         .t_dst_i(t_dst),
         .s_chr_o(sc_bus[k]),
         .t_chr_o(tc_bus[k]),
         .dst_o  (pe_dist[k])
      );
   end

   // the last source and target characters meet MID + n - m elements from the left
   int                sel;
   logic [DIST_W-1:0] pick, result;

   always_comb begin
      sel  = MID + int'(tgt_len) - int'(src_len);
      pick = '0;
      for (int k = 0; k < N_PE; k++) begin
         if (k == sel) pick = pe_dist[k];
      end
      if (src_len == '0)      result = tgt_acc;
      else if (tgt_len == '0) result = src_acc;
      else                    result = pick;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dist_o <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= fire;
         if (fire) dist_o <= result;
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);                                                   // R7

   AST_CLEAR_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (pe_dist[MID] == '0));                                      // R9

   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(dist_o));                                          // R10

endmodule

// File: tb/test_edit_dist_array.sv
module test_edit_dist_array;

   localparam int MAX_LEN = 8;
   localparam int N_PE    = 2 * MAX_LEN - 1;
   localparam int WIN     = 3 * N_PE;
   localparam int NV      = 15;

   // row: {src_len, src chars (octal digit per char, first char lowest), tgt_len, tgt chars, expected}
   // codes: A=1 C=2 G=3 T=4
   localparam logic [63:0] VEC [NV] = '{
      {4'd4, 24'o4321,     4'd4, 24'o4321,     8'd0},   // ACGT / ACGT       R5
      {4'd1, 24'o1,        4'd1, 24'o2,        8'd2},   // A / C             R2
      {4'd1, 24'o1,        4'd1, 24'o1,        8'd0},   // A / A             R5
      {4'd4, 24'o4321,     4'd4, 24'o1234,     8'd6},   // ACGT / TGCA       R2
      {4'd4, 24'o1111,     4'd2, 24'o11,       8'd2},   // AAAA / AA         R3
      {4'd7, 24'o1214413,  4'd4, 24'o1214,     8'd3},   // GATTACA / TACA    R3
      {4'd0, 24'o0,        4'd3, 24'o423,      8'd3},   // - / GCT           R4
      {4'd4, 24'o3322,     4'd0, 24'o0,        8'd4},   // CCGG / -          R4
      {4'd8, 24'o43214321, 4'd8, 24'o43214321, 8'd0},   // ACGTACGT x2       R5
      {4'd8, 24'o11111111, 4'd8, 24'o22222222, 8'd16},  // A*8 / C*8         R2 R6
      {4'd4, 24'o4321,     4'd8, 24'o11114321, 8'd4},   // ACGT / ACGTAAAA   R3
      {4'd8, 24'o21441233, 4'd3, 24'o412,      8'd5},   // GGCATTAC / CAT    R3
      {4'd3, 24'o412,      4'd8, 24'o21441233, 8'd5},   // CAT / GGCATTAC    R3
      {4'd1, 24'o4,        4'd8, 24'o43333333, 8'd7},   // T / GGGGGGGT      R3
      {4'd8, 24'o31111111, 4'd1, 24'o3,        8'd7}    // AAAAAAAG / G      R3
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] src_char, tgt_char;
   logic [7:0] dist_w;
   logic [3:0] dist_n;
   logic       done_w, done_n;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #2.5 clk = ~clk;

   edit_dist_array #(.MAX_LEN(MAX_LEN), .DIST_W(8)) i_edit_dist_array (
      .clk(clk), .rst_n(rst_n), .src_char_i(src_char), .tgt_char_i(tgt_char),
      .dist_o(dist_w), .done_o(done_w)
   );

   edit_dist_array #(.MAX_LEN(MAX_LEN), .DIST_W(4)) i_edit_dist_array_narrow (
      .clk(clk), .rst_n(rst_n), .src_char_i(src_char), .tgt_char_i(tgt_char),
      .dist_o(dist_n), .done_o(done_n)
   );

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic inject(input logic [3:0] sl, input logic [23:0] sv,
                         input logic [3:0] tl, input logic [23:0] tv);
      int mx;
      mx = (sl > tl) ? int'(sl) : int'(tl);
      for (int k = 0; k < 2 * mx; k++) begin
         @(negedge clk);
         src_char = ((k % 2) == 0 && (k / 2) < int'(sl)) ? sv[3*(k/2) +: 3] : 3'd0;
         tgt_char = ((k % 2) == 0 && (k / 2) < int'(tl)) ? tv[3*(k/2) +: 3] : 3'd0;
      end
      @(negedge clk);
      src_char = 3'd0;
      tgt_char = 3'd0;
   endtask

   // watch both copies; stop early after the wide copy's pulse when asked
   task automatic collect(input int win, input bit stop_early,
                          output int nw, output int vw, output int nn, output int vn);
      nw = 0; nn = 0; vw = 0; vn = 0;
      for (int c = 0; c < win; c++) begin
         if (c > 0) @(negedge clk);
         if (done_w) begin nw++; vw = int'(dist_w); end
         if (done_n) begin nn++; vn = int'(dist_n); end
         if (stop_early && nw > 0) break;
      end
   endtask

   function automatic string req_of(input logic [63:0] v);
      if (v[63:60] == 0 || v[35:32] == 0) return "R4";
      if (v[7:0] == 0)                    return "R5";
      if (v[63:60] != v[35:32])           return "R3";
      return "R2";
   endfunction

   initial begin
      int nw, vw, nn, vn, expn;
      src_char = 3'd0;
      tgt_char = 3'd0;
      repeat (3) @(negedge clk);
      chk(dist_w == 8'd0, "R10", "dist after reset", int'(dist_w), 0);
      chk(done_w == 1'b0, "R10", "done after reset", int'(done_w), 0);
      rst_n = 1'b1;

      // R8: idle inputs never complete a comparison
      collect(60, 1'b0, nw, vw, nn, vn);
      chk(nw == 0 && nn == 0, "R8", "done pulses while idle", nw + nn, 0);

      for (int i = 0; i < NV; i++) begin
         inject(VEC[i][63:60], VEC[i][59:36], VEC[i][35:32], VEC[i][31:8]);
         collect(WIN, 1'b0, nw, vw, nn, vn);
         expn = (int'(VEC[i][7:0]) > 15) ? 15 : int'(VEC[i][7:0]);
         chk(nw == 1 && nn == 1, "R7", $sformatf("pulse count row %0d", i), nw + nn, 2);
         chk(vw == int'(VEC[i][7:0]), req_of(VEC[i]), $sformatf("distance row %0d", i), vw, int'(VEC[i][7:0]));
         chk(vn == expn, "R6", $sformatf("4-bit distance row %0d", i), vn, expn);
         chk(int'(dist_w) == vw, "R10", $sformatf("held result row %0d", i), int'(dist_w), vw);
      end

      // R1: all four codes as distinct letters, ACGT / CGTA
      inject(4'd4, 24'o4321, 4'd4, 24'o1432);
      collect(WIN, 1'b0, nw, vw, nn, vn);
      chk(vw == 2, "R1", "four-letter rotate", vw, 2);

      // R9: back-to-back comparisons, the second starts right after the pulse
      inject(4'd8, 24'o11111111, 4'd8, 24'o22222222);
      collect(WIN, 1'b1, nw, vw, nn, vn);
      chk(vw == 16, "R9", "first of pair", vw, 16);
      inject(4'd1, 24'o1, 4'd1, 24'o1);
      collect(WIN, 1'b0, nw, vw, nn, vn);
      chk(nw == 1 && vw == 0, "R9", "second of pair", vw, 0);

      // R7: a single-character comparison finishes inside the latency bound
      inject(4'd1, 24'o3, 4'd0, 24'o0);
      collect(WIN, 1'b1, nw, vw, nn, vn);
      chk(nw == 1 && vw == 1, "R7", "pulse within bound", vw, 1);
      repeat (WIN) @(negedge clk);

      summary();
      $finish;
   end

endmodule